// File: doc/BRIEF.md
# I2C Byte Master

This block is a processor-driven master for a two-wire I2C bus that moves exactly one byte per command. Software talks to it through two byte-wide registers: a control/status register and a data register. Setting the start or stop bit in the control register puts a START or STOP condition on the bus. Writing the data register shifts a byte out and records whether the slave acknowledged it. Reading the data register returns the byte received by the previous read and also launches the reception of the next byte. A flag in the control register marks the coming read as the final one, so that the master answers it with a not-acknowledge.

Both bus wires are open-drain. Each is modelled as an output enable that pulls the line low, plus a sampled input for SDA. SCL has a fixed 50% duty cycle. Each half-period lasts two quarter slots of `QTR_CYCLES` system clocks. The engine flags a bus error and drops the bus when it releases SDA for a one bit and another driver holds the line low.

The control interface is plain register strobes. There is no valid/ready handshake at the block edge and no back-pressure: the engine accepts a command only while it is idle. A command issued while it is busy is dropped.

Top module: `i2c_byte_master`

## Requirements
- R1: Register map. Address 0 selects the control/status register and address 1 selects the data register. Control bits are: bit 0 DONE, bit 1 ACK, bit 2 BERR, bit 5 LASTRD (read/write), bit 6 STOP and bit 7 START (both write-only, they read as 0). After reset the control register reads 0x00 and both `scl_oe` and `sda_oe` are 0 (lines released).
- R2: A control write with bit 7 set, issued while idle, makes SDA fall while SCL is high. SCL is then held low and DONE sets. Data register accesses start no bus transfer while the master does not own the bus, meaning before a START, after a STOP, or after a bus error.
- R3: A data write while owning the bus sends the byte MSB first on 8 SCL pulses, then releases SDA for a ninth pulse. ACK is loaded with the inverse of SDA sampled on that pulse, in the same cycle that DONE sets.
- R4: A data read returns the previously received byte. If the bus is owned, it also clocks in 8 bits MSB first with SDA released. On the ninth pulse the master drives SDA low.
- R5: When LASTRD is 1 for a read, SDA stays released on the ninth pulse (not-acknowledge). The engine clears LASTRD at that slot. No STOP is generated and SCL stays held low.
- R6: A control write with bit 6 set, while idle and owning the bus, makes SDA rise while SCL is high. Both lines are then released and DONE sets.
- R7: During a write data bit of value 1, if SDA is sampled low while SCL is high, BERR sets. The byte is aborted without setting DONE, and both lines are released.
- R8: Any data register read or write clears BERR.
- R9: DONE clears when an accepted data access or START/STOP write launches a new operation.
- R10: During a byte, SDA changes only while SCL is low.
- R11: Register writes and data-launched transfers issued while an operation is in progress are ignored. This includes a STOP request and a LASTRD change.
- R12: During a byte, every SCL high phase lasts exactly 2*QTR_CYCLES system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | 0 = control/status, 1 = data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on the data register) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The bench builds the block with `QTR_CYCLES` set to 4. This makes one byte take 144 system clocks, so many random write and read bytes fit in a short run, together with START/STOP sequences and forced contention. With the quarter slot that short, an SCL high phase is exactly 8 clocks. The bench measures that width on every pulse and also watches for any SDA edge while SCL is high. A bus model on the bench side acknowledges or refuses writes, supplies read data, and captures the master acknowledge.

// File: rtl/i2c_pkg.sv
package i2c_pkg;
  localparam int DATA_W   = 8;
  localparam int BITN_W   = $clog2(DATA_W + 1);
  localparam int IDX_W    = $clog2(DATA_W);

  localparam int CB_DONE   = 0;
  localparam int CB_ACK    = 1;
  localparam int CB_BERR   = 2;
  localparam int CB_LASTRD = 5;
  localparam int CB_STOP   = 6;
  localparam int CB_START  = 7;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} op_t;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_STOP, ST_BYTE} eng_st_t;
endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int QTR_CYCLES = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR_CYCLES > 2) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  input  op_t               cmd_op,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              cmd_nack,
  input  logic              sda_i,
  output logic              cmd_ready,
  output logic              owned,
  output logic              in_byte,
  output logic              run,
  output logic              done_p,
  output logic              byte_done,
  output logic              berr_p,
  output logic              lastrd_clr,
  output logic              ack_bit,
  output logic              byte_rd,
  output logic [DATA_W-1:0] rx_byte,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam logic [BITN_W-1:0] ACK_SLOT = BITN_W'(DATA_W);

  eng_st_t           st;
  logic [1:0]        q;
  logic [BITN_W-1:0] bitn;
  logic [DATA_W-1:0] txb, rxb;
  logic              is_rd, nack, held, held_sda, smp;

  function automatic logic pull_for(input logic [BITN_W-1:0] b, input logic rd,
                                    input logic nk, input logic [DATA_W-1:0] tb);
    if (b == ACK_SLOT) return rd & ~nk;
    return rd ? 1'b0 : ~tb[~b[IDX_W-1:0]];
  endfunction

  assign cmd_ready = (st == ST_IDLE);
  assign run       = (st != ST_IDLE);
  assign in_byte   = (st == ST_BYTE);
  assign owned     = held;
  assign byte_rd   = is_rd;
  assign rx_byte   = rxb;
  assign ack_bit   = ~smp;

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      ST_IDLE:  begin scl_oe = held;            sda_oe = held & held_sda; end
      ST_START: begin scl_oe = (q == 2'd0) & held; sda_oe = q[1]; end
      ST_STOP:  begin scl_oe = ~q[1];           sda_oe = (q != 2'd3); end
      ST_BYTE:  begin
        scl_oe = ~q[1];
        // hold the previous bit through quarter 0 so SDA moves only with SCL low
        if (q == 2'd0 && bitn != '0) sda_oe = pull_for(bitn - 1'b1, is_rd, nack, txb);
        else                         sda_oe = pull_for(bitn, is_rd, nack, txb);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; q <= '0; bitn <= '0; txb <= '0; rxb <= '0;
      is_rd <= 1'b0; nack <= 1'b0; held <= 1'b0; held_sda <= 1'b0; smp <= 1'b1;
      done_p <= 1'b0; byte_done <= 1'b0; berr_p <= 1'b0; lastrd_clr <= 1'b0;
    end else begin
      done_p <= 1'b0; byte_done <= 1'b0; berr_p <= 1'b0; lastrd_clr <= 1'b0;
      if (st == ST_IDLE) begin
        if (cmd_valid) begin
          q    <= '0;
          bitn <= '0;
          case (cmd_op)
            OP_START: st <= ST_START;
            OP_STOP:  st <= ST_STOP;
            OP_WRITE: begin st <= ST_BYTE; is_rd <= 1'b0; txb <= cmd_byte; end
            OP_READ:  begin st <= ST_BYTE; is_rd <= 1'b1; nack <= cmd_nack; end
            default: ;
          endcase
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (st)
          ST_START: if (q == 2'd3) begin
            st <= ST_IDLE; held <= 1'b1; held_sda <= 1'b1; done_p <= 1'b1;
          end
          ST_STOP: if (q == 2'd3) begin
            st <= ST_IDLE; held <= 1'b0; held_sda <= 1'b0; done_p <= 1'b1;
          end
          ST_BYTE: begin
            if (q == 2'd2) begin
              if (bitn == ACK_SLOT) smp <= sda_i;
              else if (is_rd)       rxb <= {rxb[DATA_W-2:0], sda_i};
              else if (txb[~bitn[IDX_W-1:0]] && !sda_i) begin
                st <= ST_IDLE; held <= 1'b0; held_sda <= 1'b0; berr_p <= 1'b1;
              end
            end
            if (q == 2'd3) begin
              if (bitn == ACK_SLOT) begin
                st <= ST_IDLE; held_sda <= is_rd & ~nack;
                done_p <= 1'b1; byte_done <= 1'b1;
              end else begin
                bitn <= bitn + 1'b1;
                if (is_rd && bitn == ACK_SLOT - 1'b1) lastrd_clr <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_pkg::*;
#(
  parameter int QTR_CYCLES = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_i
);
  logic tick, run, in_byte, owned, ready;
  logic done_p, byte_done, berr_p, lastrd_clr, ack_bit, byte_rd;
  logic [DATA_W-1:0] rx_byte, rx_q;
  logic cmd_valid;
  op_t  cmd_op;
  logic done_q, ack_q, berr_q, lastrd_q;
  logic ctrl_wr, data_wr, data_rd;
  wire  unused_wbits = ^reg_wdata[4:0];

  assign ctrl_wr = reg_wr & ~reg_addr;
  assign data_wr = reg_wr &  reg_addr;
  assign data_rd = reg_rd &  reg_addr;

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_START;
    if (ready) begin
      if (ctrl_wr && reg_wdata[CB_START])              begin cmd_valid = 1'b1; cmd_op = OP_START; end
      else if (ctrl_wr && reg_wdata[CB_STOP] && owned) begin cmd_valid = 1'b1; cmd_op = OP_STOP;  end
      else if (data_wr && owned)                       begin cmd_valid = 1'b1; cmd_op = OP_WRITE; end
      else if (data_rd && owned)                       begin cmd_valid = 1'b1; cmd_op = OP_READ;  end
    end
  end

  i2c_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  i2c_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(reg_wdata), .cmd_nack(lastrd_q),
    .sda_i(sda_i), .cmd_ready(ready), .owned(owned), .in_byte(in_byte), .run(run),
    .done_p(done_p), .byte_done(byte_done), .berr_p(berr_p), .lastrd_clr(lastrd_clr),
    .ack_bit(ack_bit), .byte_rd(byte_rd), .rx_byte(rx_byte),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0; ack_q <= 1'b0; berr_q <= 1'b0; lastrd_q <= 1'b0; rx_q <= '0;
    end else begin
      if (done_p)                      done_q <= 1'b1;
      else if (ready && (data_wr || data_rd ||
               (ctrl_wr && (reg_wdata[CB_START] || reg_wdata[CB_STOP]))))
                                       done_q <= 1'b0;
      if (byte_done)                   ack_q <= ack_bit;
      if (berr_p)                      berr_q <= 1'b1;
      else if (data_wr || data_rd)     berr_q <= 1'b0;
      if (lastrd_clr)                  lastrd_q <= 1'b0;
      else if (ctrl_wr && ready)       lastrd_q <= reg_wdata[CB_LASTRD];
      if (byte_done && byte_rd)        rx_q <= rx_byte;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr) reg_rdata = rx_q;
    else begin
      reg_rdata[CB_DONE]   = done_q;
      reg_rdata[CB_ACK]    = ack_q;
      reg_rdata[CB_BERR]   = berr_q;
      reg_rdata[CB_LASTRD] = lastrd_q;
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic done_q,
  input logic berr_q,
  input logic lastrd_q,
  input logic run,
  input logic in_byte,
  input logic owned
);
  AST_NO_BYTE_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_byte) |-> $past(owned)); // R2

  AST_LASTRD_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lastrd_q) && run) |-> scl_oe); // R5

  AST_BERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_q) |-> (!scl_oe && !sda_oe)); // R7

  AST_BERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_q) |-> !done_q); // R7

  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run); // R9

  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && $past(in_byte) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe)); // R10
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .done_q(done_q), .berr_q(berr_q), .lastrd_q(lastrd_q),
  .run(run), .in_byte(in_byte), .owned(owned)
);

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;
  localparam int Q = 4;
  localparam int HI_NS = 2 * Q * 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe;
  wire  scl_line, sda_line;

  int errs = 0, checks = 0;
  bit finished = 0;

  // bus model
  logic slv_act = 1'b0, arm = 1'b0, byte_mon = 1'b0;
  int   slv_mode = 0;           // 1 write+ack, 2 write nack, 3 read, 4 contention
  logic [7:0] slv_byte = 8'h00;
  int   k = 0;
  logic [7:0] cap = 8'h00;
  logic mack = 1'b0;
  int   start_cnt = 0, stop_cnt = 0, viol = 0, bad_hi = 0, hi_n = 0;
  time  t_rise = 0;

  function automatic logic slv_drv(input int m, input int kk, input logic [7:0] b);
    if (m == 1) return kk == 8;
    if (m == 3) return (kk < 8) ? !b[7-kk] : 1'b0;
    if (m == 4) return kk == 0;
    return 1'b0;
  endfunction

  wire slv_low = slv_act && slv_drv(slv_mode, k, slv_byte);
  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_low);

  always #2 clk = ~clk;

  i2c_byte_master #(.QTR_CYCLES(Q)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_i(sda_line)
  );

  always @(negedge scl_line or posedge arm) if (arm) k <= 0; else k <= k + 1;
  always @(posedge scl_line) begin
    t_rise = $time;
    if (slv_act) begin
      if (k < 8) cap <= {cap[6:0], sda_line};
      else if (k == 8) mack <= !sda_line;
    end
  end
  always @(negedge scl_line) if (byte_mon) begin
    hi_n++;
    if ($time - t_rise != HI_NS) bad_hi++;
  end
  always @(negedge sda_line) if (scl_line === 1'b1) start_cnt++;
  always @(posedge sda_line) if (scl_line === 1'b1) stop_cnt++;
  always @(sda_line) if (byte_mon && scl_line === 1'b1) viol++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic cpu_rd_data(output logic [7:0] d);
    @(negedge clk); reg_addr = 1'b1; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic peek_ctrl(output logic [7:0] d);
    reg_addr = 1'b0; #1 d = reg_rdata;
  endtask

  task automatic wait_flag(input logic [7:0] mask);
    int n = 0;
    reg_addr = 1'b0;
    while (n < 3000 && (reg_rdata & mask) == 8'h00) begin @(negedge clk); n++; end
    if (n >= 3000) chk(0, "wait timeout", n, 0);
  endtask

  task automatic arm_slave(input int m, input logic [7:0] b);
    slv_mode = m; slv_byte = b; arm = 1'b1; #1 arm = 1'b0; slv_act = 1'b1;
  endtask

  task automatic do_start();
    logic [7:0] c; int s0 = start_cnt;
    cpu_wr(1'b0, 8'h80);
    peek_ctrl(c); chk(c[0] == 1'b0, "R9 done cleared by START", c, 0);
    wait_flag(8'h01);
    chk(start_cnt == s0 + 1, "R2 start condition", start_cnt - s0, 1);
    chk(scl_oe == 1'b1, "R2 SCL held low", scl_oe, 1);
  endtask

  task automatic do_write(input logic [7:0] b, input bit ack_en);
    logic [7:0] c;
    arm_slave(ack_en ? 1 : 2, 8'h00);
    byte_mon = 1'b1;
    cpu_wr(1'b1, b);
    peek_ctrl(c); chk(c[0] == 1'b0, "R9 done cleared by data write", c, 0);
    wait_flag(8'h01);
    byte_mon = 1'b0; slv_act = 1'b0;
    chk(cap == b, "R3 byte on bus", cap, b);
    peek_ctrl(c); chk(c[1] == ack_en, "R3 ACK status", c[1], ack_en);
  endtask

  task automatic do_read(input logic [7:0] b, input bit last, output logic [7:0] prev);
    logic [7:0] c;
    if (last) cpu_wr(1'b0, 8'h20);
    arm_slave(3, b);
    byte_mon = 1'b1;
    cpu_rd_data(prev);
    wait_flag(8'h01);
    byte_mon = 1'b0; slv_act = 1'b0;
    if (last) chk(mack == 1'b0, "R5 NACK on last read", mack, 0);
    else      chk(mack == 1'b1, "R4 master ACK", mack, 1);
    peek_ctrl(c); chk(c[5] == 1'b0, "R5 LASTRD cleared", c[5], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] c, d, prevb, got;
    int s0;
    void'($urandom(32'd20240517));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek_ctrl(c);
    chk(c == 8'h00, "R1 reset ctrl", c, 0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", {scl_oe, sda_oe}, 0);

    // data access without bus ownership
    cpu_wr(1'b1, 8'hA5);
    repeat (40) @(negedge clk);
    peek_ctrl(c);
    chk(scl_oe == 1'b0 && c[0] == 1'b0, "R2 no transfer unowned", {scl_oe, c[0]}, 0);

    do_start();
    do_write(8'h00, 1'b1);
    do_write(8'hFF, 1'b0);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = 8'($urandom);
      bit a = 1'($urandom);
      do_write(b, a);
    end

    // commands while busy are ignored
    s0 = stop_cnt;
    arm_slave(1, 8'h00);
    byte_mon = 1'b1;
    cpu_wr(1'b1, 8'h3C);
    repeat (20) @(negedge clk);
    cpu_wr(1'b1, 8'hC3);
    cpu_wr(1'b0, 8'h60);
    wait_flag(8'h01);
    byte_mon = 1'b0; slv_act = 1'b0;
    chk(cap == 8'h3C, "R11 busy write ignored", cap, 8'h3C);
    peek_ctrl(c);
    chk(stop_cnt == s0 && c[5] == 1'b0, "R11 busy ctrl ignored", {stop_cnt - s0, c[5]}, 0);

    // reads: repeated start then chained bytes
    do_start();
    prevb = 8'h00;
    for (int i = 0; i < 5; i++) begin
      logic [7:0] b = (i == 0) ? 8'h80 : 8'($urandom);
      do_read(b, 1'b0, got);
      if (i > 0) chk(got == prevb, "R4 read data", got, prevb);
      prevb = b;
    end
    s0 = stop_cnt;
    do_read(8'h5A, 1'b1, got);
    chk(got == prevb, "R4 read data", got, prevb);
    chk(stop_cnt == s0 && scl_oe == 1'b1, "R5 no auto STOP", stop_cnt - s0, 0);

    cpu_wr(1'b0, 8'h40);
    wait_flag(8'h01);
    chk(stop_cnt == s0 + 1, "R6 stop condition", stop_cnt - s0, 1);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R6 lines released", {scl_oe, sda_oe}, 0);
    cpu_rd_data(got);
    chk(got == 8'h5A, "R4 last byte readable", got, 8'h5A);
    repeat (40) @(negedge clk);
    chk(scl_oe == 1'b0, "R2 read unowned no transfer", scl_oe, 0);

    // contention, cleared by data write
    do_start();
    arm_slave(4, 8'h00);
    cpu_wr(1'b1, 8'hFF);
    wait_flag(8'h05);
    peek_ctrl(c);
    chk(c[2] == 1'b1 && c[0] == 1'b0, "R7 BERR without DONE", c[2:0], 3'b100);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R7 bus released", {scl_oe, sda_oe}, 0);
    slv_act = 1'b0;
    cpu_wr(1'b1, 8'h00);
    peek_ctrl(c);
    chk(c[2] == 1'b0, "R8 BERR cleared by write", c[2], 0);

    // contention, cleared by data read
    do_start();
    arm_slave(4, 8'h00);
    cpu_wr(1'b1, 8'hF0);
    wait_flag(8'h05);
    peek_ctrl(c);
    chk(c[2] == 1'b1, "R7 BERR set", c[2], 1);
    slv_act = 1'b0;
    cpu_rd_data(d);
    peek_ctrl(c);
    chk(c[2] == 1'b0, "R8 BERR cleared by read", c[2], 0);

    chk(viol == 0, "R10 SDA stable while SCL high", viol, 0);
    chk(hi_n > 0 && bad_hi == 0, "R12 SCL high width", bad_hi, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule